// File: doc/BRIEF.md
# Receive-Line Pulse Width Timer

This block measures how long the receive line of a serial port stays low, so that software can work out the bit period of an incoming stream from the width of a known start pulse. Software arms the timer by setting a start bit. The timer then waits for the line to fall. It counts clock cycles until the line rises again, stores that count in a result register and raises an interrupt flag. The flag stays up until software clears it with a write-one-to-clear pulse.

A completed measurement clears the start bit, and the timer goes back to idle on its own. A measurement in progress cannot be cancelled. If software drops the start bit while a count is running, the timer keeps going in a free-running mode. In that mode every later rising edge stores the cycles since the previous rising edge and raises the flag again. Setting the start bit again makes the next rising edge the last one. The line passes through a synchroniser before edge detection. Turning the count into a divisor is left to software.

Top module: `autobaud_timer`

## Requirements
- R1: After reset the timer is idle: `armed_o`, `counting_o` and `irq_o` are 0 and `result_o` is 0.
- R2: The receive line goes through a chain of `SYNC_STAGES` flops before edges are detected. A low pulse lasting L clock cycles, measured at the pin, gives a result of exactly L.
- R3: A pulse on `start_set_i` sets the start bit, shown on `armed_o`. While the start bit is set and the timer is idle, a falling edge starts a measurement: `counting_o` goes to 1 and `result_o` is cleared to 0.
- R4: While the timer is idle with the start bit clear, edges on the receive line are ignored: no interrupt, and `counting_o` stays 0.
- R5: A rising edge during a measurement stores the cycle count in `result_o` and sets `irq_o`.
- R6: If the start bit is still set at that rising edge, the timer stops: `counting_o` returns to 0 and the start bit clears itself.
- R7: If the start bit is cleared during a measurement, counting goes on. Each later rising edge stores the number of cycles since the previous rising edge, sets `irq_o`, and `counting_o` stays 1.
- R8: Setting the start bit during free-running counting makes the next rising edge stop the timer, as in R6.
- R9: Clearing the start bit while armed but not yet counting returns the timer to idle at once. The next falling edge then starts nothing.
- R10: The count saturates at 2^CNT_W−1 and does not wrap.
- R11: `irq_o` stays set until a pulse on `irq_clr_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous receive line, idle high |
| start_set_i | input | 1 | One-cycle pulse that sets the start bit |
| start_clr_i | input | 1 | One-cycle pulse that clears the start bit |
| irq_clr_i | input | 1 | One-cycle write-one-to-clear pulse for the interrupt flag |
| armed_o | output | 1 | Current value of the start bit |
| counting_o | output | 1 | Status: 1 while a measurement is running |
| result_o | output | CNT_W | Last stored cycle count |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench builds the timer with `CNT_W` = 8 and `SYNC_STAGES` = 2. With the narrow counter, a 300-cycle pulse reaches the saturation limit of 255 in a short run; the full 32-bit default would need billions of cycles. Keeping two sync stages makes the delay from pin to edge the same as in the default build. The stored width therefore equals the pin-level pulse length, and the bench can predict it exactly. Free-running intervals are predicted as the sum of the high and low times the bench drives.

// File: rtl/abt_pkg.sv
package abt_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } abt_state_e;
endpackage

// File: rtl/abt_rx_sync.sv
module abt_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[CHAIN-2:0], rx_i};
  end

  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
  assign fall_o =  chain_q[STAGES] & ~chain_q[STAGES-1];
  assign rise_o = ~chain_q[STAGES] &  chain_q[STAGES-1];
endmodule

// File: rtl/abt_sat_counter.sv
module abt_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] value_o,
  output logic [CNT_W-1:0] next_o
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [CNT_W-1:0] cnt_q;

  assign next_o  = (cnt_q == MAX_VAL) ? MAX_VAL : cnt_q + 1'b1;
  assign value_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= next_o;
  end

  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && value_o == MAX_VAL) |=> (value_o == MAX_VAL));
endmodule

// File: rtl/abt_ctrl.sv
module abt_ctrl
  import abt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             start_set_i,
  input  logic             start_clr_i,
  input  logic             irq_clr_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             armed_o,
  output logic             counting_o,
  output logic [CNT_W-1:0] result_o,
  output logic             irq_o
);
  abt_state_e       state_q, state_d;
  logic             start_q, start_d;
  logic [CNT_W-1:0] result_q;
  logic             irq_q;
  logic             begin_meas, edge_hit;

  assign begin_meas = (state_q == ST_IDLE) && start_q && fall_i;
  assign edge_hit   = (state_q == ST_COUNT) && rise_i;

  always_comb begin
    state_d = state_q;
    if (begin_meas)             state_d = ST_COUNT;
    else if (edge_hit && start_q) state_d = ST_IDLE;
  end

  always_comb begin
    start_d = start_q;
    if (start_set_i)              start_d = 1'b1;
    else if (start_clr_i)         start_d = 1'b0;
    else if (edge_hit && start_q) start_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      start_q  <= 1'b0;
      result_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      if (begin_meas)    result_q <= '0;
      else if (edge_hit) result_q <= cnt_next_i;
      if (edge_hit)       irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign cnt_clr_o  = begin_meas | edge_hit;
  assign cnt_en_o   = (state_q == ST_COUNT);
  assign armed_o    = start_q;
  assign counting_o = (state_q == ST_COUNT);
  assign result_o   = result_q;
  assign irq_o      = irq_q;

  p_idle_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counting_o && !armed_o && !start_set_i) |=> (!counting_o && !irq_o || !counting_o));
  p_edge_sets_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting_o && rise_i) |=> irq_o);
  p_self_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting_o && rise_i && armed_o && !start_set_i) |=> (!counting_o && !armed_o));
  p_free_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting_o && !armed_o) |=> counting_o);
  p_result_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !rise_i) |=> $stable(result_o));
  p_irq_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

// File: rtl/autobaud_timer.sv
module autobaud_timer #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             start_set_i,
  input  logic             start_clr_i,
  input  logic             irq_clr_i,
  output logic             armed_o,
  output logic             counting_o,
  output logic [CNT_W-1:0] result_o,
  output logic             irq_o
);
  logic             fall, rise;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt_val, cnt_next;

  abt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  abt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .value_o (cnt_val),
    .next_o  (cnt_next)
  );

  abt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall),
    .rise_i      (rise),
    .start_set_i (start_set_i),
    .start_clr_i (start_clr_i),
    .irq_clr_i   (irq_clr_i),
    .cnt_next_i  (cnt_next),
    .cnt_clr_o   (cnt_clr),
    .cnt_en_o    (cnt_en),
    .armed_o     (armed_o),
    .counting_o  (counting_o),
    .result_o    (result_o),
    .irq_o       (irq_o)
  );

  p_no_count_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counting_o && !fall) |=> ($stable(cnt_val) || !counting_o));
endmodule

// File: tb/autobaud_timer_tb.sv
module autobaud_timer_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic          sset = 1'b0, sclr = 1'b0, tb_ack = 1'b0, mon_ack = 1'b0;
  logic          armed, counting, irq;
  logic [CW-1:0] result;

  int     checks = 0, fails = 0;
  int     exp_q[$];
  string  tag_q[$];
  bit     auto_ack = 1'b1;
  bit     irq_prev = 1'b0;
  bit     done = 1'b0;

  always #4 clk = ~clk;

  autobaud_timer #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .start_set_i(sset), .start_clr_i(sclr), .irq_clr_i(tb_ack | mon_ack),
    .armed_o(armed), .counting_o(counting), .result_o(result), .irq_o(irq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: compares every new interrupt against the scoreboard
  always @(negedge clk) begin
    mon_ack <= 1'b0;
    if (rst_n && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected interrupt", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(result), exp_q.pop_front());
      end
      if (auto_ack) mon_ack <= 1'b1;
    end
    irq_prev <= irq;
  end

  task automatic expect_val(string tag, int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(int len);
    rx = 1'b0;
    idle(len);
    rx = 1'b1;
  endtask

  task automatic arm();
    sset = 1'b1; @(negedge clk); sset = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 armed", armed, 0);
    check("R1 counting", counting, 0);
    check("R1 irq", irq, 0);
    check("R1 result", result, 0);

    // R4 unarmed pulse ignored (monitor flags any interrupt)
    low_pulse(12);
    idle(8);
    check("R4 counting", counting, 0);
    check("R4 irq", irq, 0);

    // R2, R5, R6 basic measurement
    arm();
    check("R3 armed", armed, 1);
    expect_val("R2 width 10", 10);
    low_pulse(10);
    idle(8);
    check("R6 counting", counting, 0);
    check("R6 start self-clear", armed, 0);

    // R3 result cleared at new measurement, status counting
    arm();
    expect_val("R5 width 37", 37);
    rx = 1'b0;
    idle(5);
    check("R3 counting", counting, 1);
    check("R3 result cleared", result, 0);
    idle(32);
    rx = 1'b1;
    idle(8);

    // R10 saturation
    arm();
    expect_val("R10 saturate", 255);
    low_pulse(300);
    idle(8);

    // R9 clear while armed, not counting
    arm();
    sclr = 1'b1; @(negedge clk); sclr = 1'b0;
    idle(1);
    check("R9 armed", armed, 0);
    low_pulse(9);
    idle(8);
    check("R9 counting", counting, 0);

    // R7 free-running mode
    arm();
    expect_val("R7 first rise", 20);
    rx = 1'b0;
    idle(5);
    sclr = 1'b1; @(negedge clk); sclr = 1'b0;
    idle(14);
    rx = 1'b1;
    expect_val("R7 rise to rise", 27);
    idle(6);
    check("R7 still counting", counting, 1);
    check("R7 start clear", armed, 0);
    idle(9);
    low_pulse(12);
    // R8 set start again during free run
    expect_val("R8 final interval", 31);
    idle(10);
    arm();
    idle(12);
    low_pulse(8);
    idle(8);
    check("R8 stopped", counting, 0);
    check("R8 start self-clear", armed, 0);

    // R11 flag persists until cleared
    auto_ack = 1'b0;
    arm();
    expect_val("R11 width 6", 6);
    low_pulse(6);
    idle(20);
    check("R11 irq held", irq, 1);
    tb_ack = 1'b1; @(negedge clk); tb_ack = 1'b0;
    idle(1);
    check("R11 irq cleared", irq, 0);

    check("R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule